// File: doc/BRIEF.md
# Receive Sync and Sample Capture Timer

This block runs from an oscillator clock at 48 ticks per symbol. It divides that clock down to a symbol-rate baud clock. It produces a receive-sync pulse whose leading edge sits a programmable number of 1/48-symbol steps after the baud leading edge. It also latches the 14-bit two's-complement word from the receive converter twice in each symbol. The first is the primary sample, taken in the tick where sync rises. The second is the interpolated sample, taken a fixed half symbol (24 ticks) later. Each capture has its own one-cycle valid strobe. The primary strobe marks the sample meant to be used once per symbol.

The phase offset is read from the delay input while reset is held. After that it is reloaded only in the last tick of each symbol, so the sync position never moves part-way through a symbol. Because every output is derived from the 48x clock, baud, sync and capture edges are all aligned to that clock.

Top module: `rx_phase_timer`

## Requirements
- R1: While reset is held, baud_o, sync_o, prim_vld_o and mid_vld_o are low and both sample outputs are zero. The delay input is loaded as the phase for the first symbol.
- R2: In the first cycle after reset is released, baud_o rises. Its period is 48 ticks, and it is high for the first 24 ticks (tick index 0..23) of every symbol.
- R3: sync_o is high in tick n and tick n+1 of each symbol, where tick 0 is the baud leading edge. With n = 47, the second sync tick falls in tick 0 of the following symbol.
- R4: A delay value above 47 acts as 47.
- R5: A change on delay_i takes effect only at the next baud leading edge. The value present in tick 47 sets the phase for the following symbol.
- R6: The bus value present in the tick where sync rises is stored on prim_smp_o. prim_vld_o is high for exactly one cycle, in the next tick. There is one primary capture per symbol.
- R7: Exactly 24 ticks after each primary capture, the bus is stored on mid_smp_o, and mid_vld_o is high for one cycle in the next tick.
- R8: Samples pass through bit-exact as 14-bit two's complement. 0x1FFF (positive full scale) and 0x2000 (negative full scale) come out unchanged.
- R9: If the interpolated capture of one symbol falls on the same tick as the primary capture of the next symbol, both captures take place. Both strobes are then high in the same cycle, and both samples hold the same bus value.
- R10: When the phase shrinks so that the next primary capture comes less than 24 ticks after the previous one, the pending interpolated capture of the earlier symbol is still taken on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, 48 ticks per symbol |
| rst_i | input | 1 | Synchronous active-high reset |
| delay_i | input | 6 | Sync phase in 1/48-symbol steps (0..47) |
| rx_bus_i | input | 14 | Parallel two's-complement receive word |
| baud_o | output | 1 | Symbol-rate baud clock |
| sync_o | output | 1 | Receive sync pulse, 2 ticks wide |
| prim_smp_o | output | 14 | Primary sample of the current symbol |
| prim_vld_o | output | 1 | One-cycle strobe for a new primary sample |
| mid_smp_o | output | 14 | Interpolated mid-symbol sample |
| mid_vld_o | output | 1 | One-cycle strobe for a new interpolated sample |

## Verification
The interpolated capture of one symbol and the primary capture of the next land on the same tick when the phase drops by exactly 24 between symbols. The bench provokes this by stepping the delay from 30 to 6. A scoreboard then expects both strobes in the same cycle, each carrying the bus word driven in that one tick. A shrink from 40 to 3 puts a new primary capture inside the 24-tick window of the previous one, and the bench expects both interpolated captures on their own ticks.

// File: rtl/rx_phase_pkg.sv
package rx_phase_pkg;

    localparam int SYM_TICKS  = 48;
    localparam int SMP_W      = 14;
    localparam int SYNC_TICKS = 2;
    localparam int BAUD_TICKS = 24;

    // Events the phase counter hands to the sync and capture logic.
    typedef struct packed {
        logic run;
        logic sym_last;
        logic sync_hit;
    } phase_ev_t;

    // Keep a requested baud-high width inside the allowed 1/16..15/16 band.
    function automatic int baud_width(input int req, input int ticks);
        int lo;
        int hi;
        lo = (ticks + 15) / 16;
        hi = ticks - lo;
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/rx_phase_ctr.sv
module rx_phase_ctr
    import rx_phase_pkg::*;
#(
    parameter int TICKS   = SYM_TICKS,
    parameter int BAUD_HI = BAUD_TICKS,
    parameter int PH_W    = $clog2(TICKS)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [PH_W-1:0] delay_i,
    output logic [PH_W-1:0] tick_o,
    output logic [PH_W-1:0] phase_o,
    output logic            run_o,
    output logic            baud_o
);

    localparam logic [PH_W-1:0] LAST_TICK = PH_W'(TICKS - 1);
    localparam logic [PH_W-1:0] BAUD_END  = PH_W'(baud_width(BAUD_HI, TICKS));

    logic [PH_W-1:0] tick_q;
    logic [PH_W-1:0] phase_q;
    logic            run_q;
    logic [PH_W-1:0] phase_in;
    logic            sym_last;

    assign phase_in = (delay_i > LAST_TICK) ? LAST_TICK : delay_i;
    assign sym_last = run_q && (tick_q == LAST_TICK);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tick_q  <= '0;
            phase_q <= phase_in;
            run_q   <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (sym_last) begin
                tick_q  <= '0;
                phase_q <= phase_in;
            end else if (run_q) begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign tick_o  = tick_q;
    assign phase_o = phase_q;
    assign run_o   = run_q;
    assign baud_o  = run_q && (tick_q < BAUD_END);

endmodule

// File: rtl/rx_sync_gen.sv
module rx_sync_gen
    import rx_phase_pkg::*;
#(
    parameter int PH_W   = 6,
    parameter int SYNC_W = SYNC_TICKS
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            run_i,
    input  logic [PH_W-1:0] tick_i,
    input  logic [PH_W-1:0] phase_i,
    output logic            sync_o,
    output logic            hit_o
);

    localparam int TW = (SYNC_W > 1) ? $clog2(SYNC_W) + 1 : 1;

    logic hit;
    logic tail_on;

    assign hit = run_i && (tick_i == phase_i);

    generate
        if (SYNC_W > 1) begin : g_tail
            logic [TW-1:0] tail_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    tail_q <= '0;
                end else if (hit) begin
                    tail_q <= TW'(SYNC_W - 1);
                end else if (tail_q != '0) begin
                    tail_q <= tail_q - 1'b1;
                end
            end
            assign tail_on = (tail_q != '0);
        end else begin : g_notail
            assign tail_on = 1'b0;
        end
    endgenerate

    assign sync_o = hit || tail_on;
    assign hit_o  = hit;

endmodule

// File: rtl/rx_sample_cap.sv
module rx_sample_cap
    import rx_phase_pkg::*;
#(
    parameter int DW      = SMP_W,
    parameter int MID_OFF = SYM_TICKS / 2
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          hit_i,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] prim_o,
    output logic          prim_vld_o,
    output logic [DW-1:0] mid_o,
    output logic          mid_vld_o
);

    localparam int NSLOT = 2;
    localparam int MW    = $clog2(MID_OFF + 1);

    logic             sel_q;
    logic [NSLOT-1:0] fire_v;
    logic             mid_fire;

    // Two countdown slots so a short phase step cannot drop a pending mid capture.
    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            logic [MW-1:0] cnt_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    cnt_q <= '0;
                end else if (hit_i && (sel_q == 1'(g))) begin
                    cnt_q <= MW'(MID_OFF);
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            assign fire_v[g] = (cnt_q == MW'(1));
        end
    endgenerate

    assign mid_fire = |fire_v;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_q      <= 1'b0;
            prim_o     <= '0;
            prim_vld_o <= 1'b0;
            mid_o      <= '0;
            mid_vld_o  <= 1'b0;
        end else begin
            prim_vld_o <= hit_i;
            mid_vld_o  <= mid_fire;
            if (hit_i) begin
                prim_o <= bus_i;
                sel_q  <= ~sel_q;
            end
            if (mid_fire) begin
                mid_o <= bus_i;
            end
        end
    end

endmodule

// File: rtl/rx_phase_timer.sv
module rx_phase_timer
    import rx_phase_pkg::*;
#(
    parameter int TICKS_PER_SYM = SYM_TICKS,
    parameter int DATA_W        = SMP_W,
    parameter int SYNC_W        = SYNC_TICKS,
    parameter int BAUD_HIGH     = BAUD_TICKS,
    parameter int MID_OFFSET    = TICKS_PER_SYM / 2,
    localparam int PH_W         = $clog2(TICKS_PER_SYM)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [PH_W-1:0]   delay_i,
    input  logic [DATA_W-1:0] rx_bus_i,
    output logic              baud_o,
    output logic              sync_o,
    output logic [DATA_W-1:0] prim_smp_o,
    output logic              prim_vld_o,
    output logic [DATA_W-1:0] mid_smp_o,
    output logic              mid_vld_o
);

    logic [PH_W-1:0] tick;
    logic [PH_W-1:0] phase;
    phase_ev_t       ev;

    assign ev.sym_last = ev.run && (tick == PH_W'(TICKS_PER_SYM - 1));

    rx_phase_ctr #(
        .TICKS   (TICKS_PER_SYM),
        .BAUD_HI (BAUD_HIGH),
        .PH_W    (PH_W)
    ) u_ctr (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .delay_i (delay_i),
        .tick_o  (tick),
        .phase_o (phase),
        .run_o   (ev.run),
        .baud_o  (baud_o)
    );

    rx_sync_gen #(
        .PH_W   (PH_W),
        .SYNC_W (SYNC_W)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_i   (ev.run),
        .tick_i  (tick),
        .phase_i (phase),
        .sync_o  (sync_o),
        .hit_o   (ev.sync_hit)
    );

    rx_sample_cap #(
        .DW      (DATA_W),
        .MID_OFF (MID_OFFSET)
    ) u_cap (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .hit_i      (ev.sync_hit),
        .bus_i      (rx_bus_i),
        .prim_o     (prim_smp_o),
        .prim_vld_o (prim_vld_o),
        .mid_o      (mid_smp_o),
        .mid_vld_o  (mid_vld_o)
    );

    logic unused_last;
    assign unused_last = ev.sym_last;

endmodule

// File: rtl/rx_phase_timer_chk.sv
module rx_phase_timer_chk #(
    parameter int TICKS = 48,
    parameter int DW    = 14
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          baud_o,
    input logic          sync_o,
    input logic          prim_vld_o,
    input logic          mid_vld_o,
    input logic [DW-1:0] prim_smp_o,
    input logic [DW-1:0] mid_smp_o,
    input logic [DW-1:0] rx_bus_i
);

    logic        baud_d_q;
    logic        seen_q;
    logic [15:0] gap_q;
    logic        baud_rise;

    assign baud_rise = baud_o && !baud_d_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            baud_d_q <= 1'b0;
            seen_q   <= 1'b0;
            gap_q    <= '0;
        end else begin
            baud_d_q <= baud_o;
            if (baud_rise) begin
                seen_q <= 1'b1;
                gap_q  <= '0;
            end else if (gap_q != 16'hFFFF) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    a_r1_quiet_in_reset: assert property (@(posedge clk_i)
        rst_i |=> (!baud_o && !sync_o && !prim_vld_o && !mid_vld_o));

    a_r2_baud_period: assert property (@(posedge clk_i) disable iff (rst_i)
        (baud_rise && seen_q) |-> (gap_q == 16'(TICKS - 1)));

    a_r6_prim_after_sync: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sync_o) |=> prim_vld_o);

    a_r6_prim_single: assert property (@(posedge clk_i) disable iff (rst_i)
        prim_vld_o |=> !prim_vld_o);

    a_r7_mid_single: assert property (@(posedge clk_i) disable iff (rst_i)
        mid_vld_o |=> !mid_vld_o);

    a_r8_prim_data: assert property (@(posedge clk_i) disable iff (rst_i)
        prim_vld_o |-> (prim_smp_o == $past(rx_bus_i)));

    a_r8_mid_data: assert property (@(posedge clk_i) disable iff (rst_i)
        mid_vld_o |-> (mid_smp_o == $past(rx_bus_i)));

endmodule

bind rx_phase_timer rx_phase_timer_chk #(
    .TICKS (TICKS_PER_SYM),
    .DW    (DATA_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .baud_o     (baud_o),
    .sync_o     (sync_o),
    .prim_vld_o (prim_vld_o),
    .mid_vld_o  (mid_vld_o),
    .prim_smp_o (prim_smp_o),
    .mid_smp_o  (mid_smp_o),
    .rx_bus_i   (rx_bus_i)
);

// File: tb/rx_phase_timer_tb_top.sv
module rx_phase_timer_tb_top;

    localparam int T  = 48;
    localparam int NS = 13;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  delay;
    logic [13:0] bus;
    logic        baud, sync, pvld, mvld;
    logic [13:0] psmp, msmp;

    always #10 clk = ~clk;

    rx_phase_timer dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .delay_i    (delay),
        .rx_bus_i   (bus),
        .baud_o     (baud),
        .sync_o     (sync),
        .prim_smp_o (psmp),
        .prim_vld_o (pvld),
        .mid_smp_o  (msmp),
        .mid_vld_o  (mvld)
    );

    typedef struct {
        int          due;
        logic [13:0] data;
        string       tag;
    } exp_t;

    exp_t  pq[$];
    exp_t  mq[$];
    int    msched[$];
    string mtag[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    int sched[NS] = '{10, 10, 0, 5, 47, 30, 6, 40, 3, 63, 20, 20, 5};

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int clamp47(input int d);
        return (d > T - 1) ? T - 1 : d;
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor: compare strobes against the expected queues.
    task automatic monitor(input int c);
        exp_t e;
        if (pvld) begin
            if (pq.size() == 0) begin
                chk(1'b0, "R6", "unexpected primary strobe at cycle", c, -1);
            end else begin
                e = pq.pop_front();
                chk(e.due == c, e.tag, "primary strobe cycle", c, e.due);
                chk(psmp == e.data, e.tag, "primary sample", psmp, e.data);
            end
        end else if (pq.size() != 0 && pq[0].due <= c) begin
            e = pq.pop_front();
            chk(1'b0, e.tag, "missing primary strobe", c, e.due);
        end
        if (mvld) begin
            if (mq.size() == 0) begin
                chk(1'b0, "R7", "unexpected mid strobe at cycle", c, -1);
            end else begin
                e = mq.pop_front();
                chk(e.due == c, e.tag, "mid strobe cycle", c, e.due);
                chk(msmp == e.data, e.tag, "mid sample", msmp, e.data);
            end
        end else if (mq.size() != 0 && mq[0].due <= c) begin
            e = mq.pop_front();
            chk(1'b0, e.tag, "missing mid strobe", c, e.due);
        end
    endtask

    initial begin
        int    n_cur;
        bit    prev_hit;
        logic [13:0] val;
        string stag;
        rst   = 1'b1;
        delay = 6'(sched[0]);
        bus   = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            // R1: reset state
            chk(!baud && !sync, "R1", "baud/sync in reset", {baud, sync}, 0);
            chk(!pvld && !mvld, "R1", "strobes in reset", {pvld, mvld}, 0);
            chk(psmp == 0 && msmp == 0, "R1", "samples in reset", psmp | msmp, 0);
        end
        rst      = 1'b0;
        n_cur    = clamp47(sched[0]);
        prev_hit = 1'b0;
        for (int s = 0; s < NS; s++) begin
            for (int t = 0; t < T; t++) begin
                int c;
                bit hit;
                c = s * T + t;
                @(negedge clk);
                hit = (t == n_cur);
                // R2: baud high for ticks 0..23
                chk(baud == (t < 24), "R2", "baud level", baud, (t < 24));
                if (sched[s] > T - 1)           stag = "R4";
                else if (int'(delay) != sched[s]) stag = "R5";
                else                              stag = "R3";
                chk(sync == (hit || prev_hit), stag, "sync level", sync, (hit || prev_hit));
                monitor(c);
                // Drive the bus for this tick.
                if (hit && s == 2)      val = 14'h1FFF;
                else if (hit && s == 3) val = 14'h2000;
                else                    val = 14'((c * 421 + 341) & 16'h3FFF);
                bus = val;
                if (hit) begin
                    pq.push_back('{c + 1, val, (s == 2 || s == 3) ? "R8" : "R6"});
                    msched.push_back(c + 24);
                    mtag.push_back((s == 7) ? "R10" : "R7");
                end
                if (msched.size() != 0 && msched[0] == c) begin
                    string mt;
                    void'(msched.pop_front());
                    mt = mtag.pop_front();
                    mq.push_back('{c + 1, val, hit ? "R9" : mt});
                end
                // Change the delay mid-symbol; it must only apply from the next symbol (R5).
                if (t == 1 && s + 1 < NS) delay = 6'(sched[s + 1]);
                if (t == T - 1) n_cur = clamp47(int'(delay));
                prev_hit = hit;
            end
        end
        @(negedge clk);
        monitor(NS * T);
        chk(pq.size() == 0, "R6", "primary captures left pending", pq.size(), 0);
        chk(mq.size() == 0 && msched.size() == 0, "R7", "mid captures left pending",
            mq.size() + msched.size(), 0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

endmodule